// File: doc/BRIEF.md
# Cumulative-Benefit Coprocessor Load Manager

This block decides, one application request at a time, whether the hardware accelerator that belongs to the requested application should be brought into a reconfigurable region of limited size. For every application it keeps a running score: the time the accelerator would have saved had it always been used. Before each request every score is scaled by a fade factor, so old history counts for less. The requested application's score then grows by its per-run saving, which is its software run time minus its accelerator run time.

An accelerator is worth loading only once its score is strictly larger than its own loading cost. This rent-until-you-could-have-bought reasoning bounds the wasted reconfiguration effort. When the region is full, the block looks for residents to evict, cheapest score first. It goes ahead only when the candidate's score minus its loading cost beats the summed scores of everything it would push out.

Per-application software time, accelerator time, loading time and slot footprint are held on configuration inputs, together with the region size and the fade factor. Each decision comes back as a one-cycle pulse. The pulse carries a load flag, a victim mask and an already-resident flag. The block does not perform the reconfiguration itself.

Top module: `cbm_load_manager`

## Requirements
- R1: Each accepted request for application a adds the saving sw_time[a] - cp_time[a] to that application's score, or adds 0 when cp_time[a] >= sw_time[a].
- R2: On each accepted request, before the saving is added, every score is replaced by floor(score * F / 2^FADE_W). F is fade_i, and any code above 2^FADE_W counts as exactly 2^FADE_W, which means no fading.
- R3: A score saturates at 2^CB_W - 1 instead of wrapping.
- R4: A non-resident accelerator can be loaded only when its score is strictly greater than its loading time. Otherwise the decision is no load with an empty victim mask.
- R5: A request for an application whose accelerator is resident returns dec_resident_o=1, dec_load_o=0 and an empty victim mask.
- R6: If the free slots (region_slots_i minus the summed footprints of residents, floored at 0) are at least the candidate's footprint, the candidate is loaded with an empty victim mask.
- R7: Otherwise residents are taken as victims in ascending order of score, with the lower index first on a tie. Taking stops as soon as the free slots plus the victims' footprints cover the candidate's footprint. Bit i of dec_victims_o marks application i.
- R8: A load with victims happens only if the candidate's score minus its loading time is strictly greater than the victims' summed score. If that sum is reached or exceeded, or the residents run out, the result is no load, no victims and no change to residency.
- R9: req_ready_o is high only while idle, and a request is taken on req_valid_i && req_ready_o. dec_valid_o is a single-cycle pulse. It comes 2 cycles after the accepting edge, plus 1 cycle for each victim examined, plus 1 if the residents run out. req_ready_o stays low from acceptance until the pulse.
- R10: A loaded accelerator is resident for later requests, and evicted ones are not.
- R11: After reset every score is 0, nothing is resident, req_ready_o=1 and dec_valid_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_app_i | input | IDX_W | Requested application index |
| req_ready_o | output | 1 | Block idle, request can be taken |
| sw_time_i | input | NUM_APPS x TIME_W | Software run time per application |
| cp_time_i | input | NUM_APPS x TIME_W | Accelerator run time per application |
| load_time_i | input | NUM_APPS x TIME_W | Loading cost per application |
| slot_size_i | input | NUM_APPS x SZ_W | Region footprint per accelerator, in slots |
| region_slots_i | input | SLOT_W | Region capacity in slots |
| fade_i | input | FADE_W+1 | Fade factor, value F means F / 2^FADE_W |
| dec_valid_o | output | 1 | Decision pulse |
| dec_load_o | output | 1 | Load the candidate |
| dec_resident_o | output | 1 | Candidate was already resident |
| dec_victims_o | output | NUM_APPS | Residents to evict |

## Verification
Two things can meet in a single update: the fade of the requested score and the saturating addition of its saving. A run with fade 1.0, a 4095 saving and a 4095 loading cost provokes this. A footprint larger than the region rejects the first sixteen requests; the region is then enlarged. The seventeenth request must load, which happens only if the score clamped rather than wrapped to 4079. The victim walk and the replacement comparison can also settle on the same cycle, when the sum first equals the margin. Directed equal-margin cases and seeded random traffic cover this. A bench model predicts the load flag, the victim mask and the exact pulse cycle for every request.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_SCAN = 2'd2
    } cbm_state_e;
endpackage

// File: rtl/cbm_fade_accum.sv
// Fades every score and adds the saving to the selected one, with saturation.
module cbm_fade_accum #(
    parameter int NUM_APPS = 4,
    parameter int CB_W     = 16,
    parameter int TIME_W   = 12,
    parameter int FADE_W   = 8
) (
    input  logic [NUM_APPS-1:0][CB_W-1:0] cb_i,
    input  logic [NUM_APPS-1:0]           sel_i,
    input  logic [TIME_W-1:0]             gain_i,
    input  logic [FADE_W:0]               fade_i,
    output logic [NUM_APPS-1:0][CB_W-1:0] cb_o
);
    localparam int PW = CB_W + FADE_W + 1;
    localparam logic [FADE_W:0] UNITY = {1'b1, {FADE_W{1'b0}}};

    logic [FADE_W:0] fade_eff;
    assign fade_eff = (fade_i > UNITY) ? UNITY : fade_i;

    for (genvar g = 0; g < NUM_APPS; g++) begin : g_entry
        logic [CB_W-1:0] faded;
        logic [CB_W:0]   sum;
        assign faded = CB_W'((PW'(cb_i[g]) * PW'(fade_eff)) >> FADE_W);
        assign sum   = {1'b0, faded} + (sel_i[g] ? (CB_W+1)'(gain_i) : '0);
        assign cb_o[g] = sum[CB_W] ? {CB_W{1'b1}} : sum[CB_W-1:0];
    end
endmodule

// File: rtl/cbm_min_pick.sv
// One-hot pick of the eligible entry with the smallest score (lowest index on tie).
module cbm_min_pick #(
    parameter int NUM_APPS = 4,
    parameter int CB_W     = 16
) (
    input  logic [NUM_APPS-1:0][CB_W-1:0] cb_i,
    input  logic [NUM_APPS-1:0]           elig_i,
    output logic [NUM_APPS-1:0]           pick_o,
    output logic                          found_o
);
    logic [CB_W-1:0] best;
    always_comb begin
        pick_o  = '0;
        found_o = 1'b0;
        best    = '0;
        for (int i = 0; i < NUM_APPS; i++) begin
            if (elig_i[i] && (!found_o || cb_i[i] < best)) begin
                pick_o    = '0;
                pick_o[i] = 1'b1;
                best      = cb_i[i];
                found_o   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cbm_slot_count.sv
// Sums the footprints of the masked accelerators.
module cbm_slot_count #(
    parameter int NUM_APPS = 4,
    parameter int SZ_W     = 2,
    parameter int CNT_W    = 5
) (
    input  logic [NUM_APPS-1:0][SZ_W-1:0] size_i,
    input  logic [NUM_APPS-1:0]           mask_i,
    output logic [CNT_W-1:0]              total_o
);
    always_comb begin
        total_o = '0;
        for (int i = 0; i < NUM_APPS; i++) begin
            if (mask_i[i]) total_o = total_o + CNT_W'(size_i[i]);
        end
    end
endmodule

// File: rtl/cbm_load_manager.sv
module cbm_load_manager
    import cbm_pkg::*;
#(
    parameter int  NUM_APPS = 4,
    parameter int  CB_W     = 16,
    parameter int  TIME_W   = 12,
    parameter int  FADE_W   = 8,
    parameter int  SZ_W     = 2,
    parameter int  SLOT_W   = 4,
    localparam int IDX_W    = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            req_valid_i,
    input  logic [IDX_W-1:0]                req_app_i,
    output logic                            req_ready_o,
    input  logic [NUM_APPS-1:0][TIME_W-1:0] sw_time_i,
    input  logic [NUM_APPS-1:0][TIME_W-1:0] cp_time_i,
    input  logic [NUM_APPS-1:0][TIME_W-1:0] load_time_i,
    input  logic [NUM_APPS-1:0][SZ_W-1:0]   slot_size_i,
    input  logic [SLOT_W-1:0]               region_slots_i,
    input  logic [FADE_W:0]                 fade_i,
    output logic                            dec_valid_o,
    output logic                            dec_load_o,
    output logic                            dec_resident_o,
    output logic [NUM_APPS-1:0]             dec_victims_o
);
    localparam int SUM_W = CB_W + IDX_W + 1;
    localparam int CNT_W = SZ_W + IDX_W + 1;
    localparam int CMP_W = ((CNT_W > SLOT_W) ? CNT_W : SLOT_W) + 1;

    typedef struct packed {
        cbm_state_e                   state;
        logic [IDX_W-1:0]             app;
        logic [NUM_APPS-1:0]          resident;
        logic [NUM_APPS-1:0][CB_W-1:0] cb;
        logic [NUM_APPS-1:0]          vmask;
        logic [SUM_W-1:0]             vsum;
        logic                         valid;
        logic                         load;
        logic                         hit;
        logic [NUM_APPS-1:0]          victims;
    } regs_t;

    regs_t r_d, r_q;

    // request-side values
    logic [NUM_APPS-1:0]           sel_req;
    logic [TIME_W-1:0]             gain;
    logic [NUM_APPS-1:0][CB_W-1:0] faded_cb;

    always_comb begin
        sel_req = '0;
        sel_req[req_app_i] = 1'b1;
        gain = (sw_time_i[req_app_i] > cp_time_i[req_app_i])
             ? (sw_time_i[req_app_i] - cp_time_i[req_app_i]) : '0;
    end

    cbm_fade_accum #(
        .NUM_APPS(NUM_APPS), .CB_W(CB_W), .TIME_W(TIME_W), .FADE_W(FADE_W)
    ) i_fade (
        .cb_i(r_q.cb), .sel_i(sel_req), .gain_i(gain), .fade_i(fade_i), .cb_o(faded_cb)
    );

    // victim walk
    logic [NUM_APPS-1:0] pick;
    logic                found;
    logic [CNT_W-1:0]    used_slots;
    logic [CNT_W-1:0]    after_slots;

    cbm_min_pick #(.NUM_APPS(NUM_APPS), .CB_W(CB_W)) i_pick (
        .cb_i(r_q.cb), .elig_i(r_q.resident & ~r_q.vmask), .pick_o(pick), .found_o(found)
    );

    cbm_slot_count #(.NUM_APPS(NUM_APPS), .SZ_W(SZ_W), .CNT_W(CNT_W)) i_used (
        .size_i(slot_size_i), .mask_i(r_q.resident), .total_o(used_slots)
    );

    cbm_slot_count #(.NUM_APPS(NUM_APPS), .SZ_W(SZ_W), .CNT_W(CNT_W)) i_after (
        .size_i(slot_size_i), .mask_i(r_q.vmask | pick), .total_o(after_slots)
    );

    logic [CB_W-1:0]  cur_cb;
    logic [CB_W-1:0]  cur_lt;
    logic [CMP_W-1:0] cur_sz;
    logic [CMP_W-1:0] free_slots;
    logic [CB_W-1:0]  margin;
    logic [CB_W-1:0]  pick_cb;
    logic [SUM_W-1:0] next_sum;
    logic [NUM_APPS-1:0] app_bit;

    always_comb begin
        cur_cb  = r_q.cb[r_q.app];
        cur_lt  = CB_W'(load_time_i[r_q.app]);
        cur_sz  = CMP_W'(slot_size_i[r_q.app]);
        free_slots = (CMP_W'(region_slots_i) > CMP_W'(used_slots))
                   ? (CMP_W'(region_slots_i) - CMP_W'(used_slots)) : '0;
        margin  = cur_cb - cur_lt;
        pick_cb = '0;
        for (int i = 0; i < NUM_APPS; i++) begin
            if (pick[i]) pick_cb = pick_cb | r_q.cb[i];
        end
        next_sum = r_q.vsum + SUM_W'(pick_cb);
        app_bit  = '0;
        app_bit[r_q.app] = 1'b1;
    end

    always_comb begin
        r_d         = r_q;
        r_d.valid   = 1'b0;
        r_d.load    = 1'b0;
        r_d.hit     = 1'b0;
        r_d.victims = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    r_d.app   = req_app_i;
                    r_d.cb    = faded_cb;
                    r_d.state = ST_EVAL;
                end
            end
            ST_EVAL: begin
                r_d.vmask = '0;
                r_d.vsum  = '0;
                if (r_q.resident[r_q.app]) begin
                    r_d.valid = 1'b1;
                    r_d.hit   = 1'b1;
                    r_d.state = ST_IDLE;
                end else if (cur_cb <= cur_lt) begin
                    r_d.valid = 1'b1;
                    r_d.state = ST_IDLE;
                end else if (free_slots >= cur_sz) begin
                    r_d.valid    = 1'b1;
                    r_d.load     = 1'b1;
                    r_d.resident = r_q.resident | app_bit;
                    r_d.state    = ST_IDLE;
                end else begin
                    r_d.state = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (!found || next_sum >= SUM_W'(margin)) begin
                    r_d.valid = 1'b1;
                    r_d.state = ST_IDLE;
                end else if (free_slots + CMP_W'(after_slots) >= cur_sz) begin
                    r_d.valid    = 1'b1;
                    r_d.load     = 1'b1;
                    r_d.victims  = r_q.vmask | pick;
                    r_d.resident = (r_q.resident & ~(r_q.vmask | pick)) | app_bit;
                    r_d.state    = ST_IDLE;
                end else begin
                    r_d.vmask = r_q.vmask | pick;
                    r_d.vsum  = next_sum;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    logic [NUM_APPS-1:0] resident_w;
    assign resident_w     = r_q.resident;
    assign req_ready_o    = (r_q.state == ST_IDLE);
    assign dec_valid_o    = r_q.valid;
    assign dec_load_o     = r_q.load;
    assign dec_resident_o = r_q.hit;
    assign dec_victims_o  = r_q.victims;
endmodule

// File: rtl/cbm_load_manager_chk.sv
module cbm_load_manager_chk #(
    parameter int NUM_APPS = 4
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                req_valid_i,
    input logic                req_ready_i,
    input logic                dec_valid_i,
    input logic                dec_load_i,
    input logic                dec_resident_i,
    input logic [NUM_APPS-1:0] dec_victims_i,
    input logic [NUM_APPS-1:0] resident_i
);
    p_pulse_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_valid_i |=> !dec_valid_i);

    p_busy_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_i) |=> (!req_ready_i && !dec_valid_i));

    p_ready_at_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_valid_i |-> req_ready_i);

    p_hit_exclusive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_i && dec_resident_i) |-> (!dec_load_i && dec_victims_i == '0));

    p_victims_need_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_i && !dec_load_i) |-> (dec_victims_i == '0));

    p_reject_keeps_residency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_i && !dec_load_i) |-> $stable(resident_i));

    p_residency_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dec_valid_i |-> $stable(resident_i));

    p_victims_were_resident_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_i && dec_victims_i != '0) |->
            (($past(resident_i) & dec_victims_i) == dec_victims_i));

    p_victims_evicted_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_valid_i |-> ((resident_i & dec_victims_i) == '0));
endmodule

bind cbm_load_manager cbm_load_manager_chk #(.NUM_APPS(NUM_APPS)) i_chk (
    .clk_i(clk_i),
    .rst_ni(rst_ni),
    .req_valid_i(req_valid_i),
    .req_ready_i(req_ready_o),
    .dec_valid_i(dec_valid_o),
    .dec_load_i(dec_load_o),
    .dec_resident_i(dec_resident_o),
    .dec_victims_i(dec_victims_o),
    .resident_i(resident_w)
);

// File: tb/test_cbm_load_manager.sv
`timescale 1ns/1ps
module test_cbm_load_manager;
    localparam int N = 4;
    localparam longint CB_MAX = 65535;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_app = '0;
    logic req_ready;
    logic [N-1:0][11:0] sw_p, cp_p, lt_p;
    logic [N-1:0][1:0]  sz_p;
    logic [3:0] cap_p;
    logic [8:0] fade_p;
    logic dec_valid, dec_load, dec_hit;
    logic [N-1:0] dec_vic;

    int sw[N], cp[N], lt[N], sz[N];
    int cap, fade;
    longint m_cb[N];
    bit     m_res[N];
    int n_checks = 0, n_err = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            sw_p[i] = sw[i][11:0];
            cp_p[i] = cp[i][11:0];
            lt_p[i] = lt[i][11:0];
            sz_p[i] = sz[i][1:0];
        end
        cap_p  = cap[3:0];
        fade_p = fade[8:0];
    end

    cbm_load_manager #(.NUM_APPS(N), .CB_W(16), .TIME_W(12), .FADE_W(8),
                       .SZ_W(2), .SLOT_W(4)) i_cbm_load_manager (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_app_i(req_app),
        .req_ready_o(req_ready), .sw_time_i(sw_p), .cp_time_i(cp_p),
        .load_time_i(lt_p), .slot_size_i(sz_p), .region_slots_i(cap_p),
        .fade_i(fade_p), .dec_valid_o(dec_valid), .dec_load_o(dec_load),
        .dec_resident_o(dec_hit), .dec_victims_o(dec_vic)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Bench model of the decision rules
    task automatic model_req(input int a, output bit e_load, output bit e_hit,
                             output bit [N-1:0] e_vic, output int e_cyc);
        longint fe, margin, vs;
        int used, freeslots, vsl;
        fe = (fade > 256) ? 256 : fade;
        for (int i = 0; i < N; i++) m_cb[i] = (m_cb[i] * fe) >> 8;
        m_cb[a] = m_cb[a] + ((sw[a] > cp[a]) ? sw[a] - cp[a] : 0);
        if (m_cb[a] > CB_MAX) m_cb[a] = CB_MAX;
        e_cyc = 2; e_load = 0; e_hit = 0; e_vic = '0;
        if (m_res[a]) e_hit = 1;
        else if (m_cb[a] > lt[a]) begin
            used = 0;
            for (int i = 0; i < N; i++) if (m_res[i]) used += sz[i];
            freeslots = (cap > used) ? cap - used : 0;
            if (freeslots >= sz[a]) e_load = 1;
            else begin
                margin = m_cb[a] - lt[a];
                vs = 0; vsl = 0;
                for (int k = 0; k <= N; k++) begin
                    int best;
                    best = -1;
                    e_cyc++;
                    for (int i = 0; i < N; i++)
                        if (m_res[i] && !e_vic[i] && (best < 0 || m_cb[i] < m_cb[best])) best = i;
                    if (best < 0) break;
                    e_vic[best] = 1'b1;
                    vs += m_cb[best];
                    if (vs >= margin) break;
                    vsl += sz[best];
                    if (freeslots + vsl >= sz[a]) begin e_load = 1; break; end
                end
                if (!e_load) e_vic = '0;
            end
        end
        if (e_load) begin
            for (int i = 0; i < N; i++) if (e_vic[i]) m_res[i] = 0;
            m_res[a] = 1;
        end
    endtask

    task automatic do_req(input int a, input string tag, output bit g_load, output bit g_hit);
        bit e_load, e_hit, busy_ok;
        bit [N-1:0] e_vic;
        int e_cyc, cyc;
        model_req(a, e_load, e_hit, e_vic, e_cyc);
        @(negedge clk);
        check(req_ready && !dec_valid, "R9", "idle before request", {req_ready, dec_valid}, 2);
        req_valid = 1'b1;
        req_app = a[1:0];
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        busy_ok = 1;
        while (!dec_valid && cyc < 60) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
            cyc++;
        end
        check(dec_valid, "R9", "decision pulse seen", dec_valid, 1);
        check(cyc == e_cyc, "R9", "decision latency", cyc, e_cyc);
        check(busy_ok, "R9", "ready low while busy", busy_ok, 1);
        check(dec_load == e_load, tag, "load flag", dec_load, e_load);
        check(dec_hit == e_hit, "R5", "resident flag", dec_hit, e_hit);
        check(dec_vic == e_vic, "R7", "victim mask", dec_vic, e_vic);
        g_load = dec_load;
        g_hit = dec_hit;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        for (int i = 0; i < N; i++) begin m_cb[i] = 0; m_res[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        bit gl, gh;
        bit exp_l[5];
        bit exp_h[5];
        int seq[5];
        // Phase A: threshold and residency (R11, R1, R4, R5)
        for (int i = 0; i < N; i++) begin lt[i] = 200; sz[i] = 1; end
        sw[0] = 200; cp[0] = 10; sw[1] = 100; cp[1] = 20;
        sw[2] = 50;  cp[2] = 25; sw[3] = 30;  cp[3] = 40;
        cap = 4; fade = 256;
        do_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
        check(dec_valid == 1'b0, "R11", "no pulse after reset", dec_valid, 0);
        seq = '{0, 0, 1, 2, 0};
        exp_l = '{0, 1, 0, 0, 0};
        exp_h = '{0, 0, 0, 0, 1};
        for (int k = 0; k < 5; k++) begin
            do_req(seq[k], "R4", gl, gh);
            check(gl == exp_l[k], "R1", "example load", gl, exp_l[k]);
            check(gh == exp_h[k], "R10", "example resident", gh, exp_h[k]);
        end
        do_req(3, "R1", gl, gh);
        check(gl == 0, "R1", "zero saving never loads", gl, 0);

        // Phase B: fade applied before accumulation (R2)
        do_reset();
        sw[0] = 130; cp[0] = 10; fade = 128;
        for (int k = 0; k < 3; k++) begin
            do_req(0, "R2", gl, gh);
            check(gl == (k == 2), "R2", "faded load step", gl, (k == 2));
        end

        // Phase C: saturation (R3)
        do_reset();
        fade = 256; cap = 1;
        sw[1] = 4095; cp[1] = 0; lt[1] = 4095; sz[1] = 2;
        for (int k = 0; k < 16; k++) do_req(1, "R3", gl, gh);
        cap = 2;
        do_req(1, "R3", gl, gh);
        check(gl == 1, "R3", "saturated score loads", gl, 1);

        // Phase D: replacement boundary and ordering (R6, R7, R8)
        do_reset();
        fade = 256; cap = 2;
        for (int i = 0; i < N; i++) begin lt[i] = 100; sz[i] = 1; cp[i] = 0; end
        sw[0] = 150; sw[1] = 300; sw[2] = 250; sw[3] = 1000; sz[3] = 2;
        do_req(0, "R6", gl, gh);
        do_req(1, "R6", gl, gh);
        do_req(2, "R8", gl, gh);
        check(gl == 0, "R8", "equal margin rejects", gl, 0);
        do_req(2, "R8", gl, gh);
        check(gl == 1 && dec_vic == 4'b0001, "R7", "single victim", dec_vic, 1);
        do_req(3, "R7", gl, gh);
        check(gl == 1 && dec_vic == 4'b0110, "R7", "two victims ascending", dec_vic, 6);
        do_req(0, "R10", gl, gh);
        check(gh == 0, "R10", "evicted not resident", gh, 0);

        // Phase E: seeded random traffic
        do_reset();
        void'($urandom(32'd7321));
        for (int blk = 0; blk < 8; blk++) begin
            for (int i = 0; i < N; i++) begin
                sw[i] = int'($urandom_range(600, 0));
                cp[i] = int'($urandom_range(300, 0));
                lt[i] = int'($urandom_range(800, 50));
                sz[i] = int'($urandom_range(2, 1));
            end
            cap = int'($urandom_range(4, 2));
            case ($urandom_range(3, 0))
                0: fade = 256;
                1: fade = 240;
                2: fade = 192;
                default: fade = 300;
            endcase
            for (int k = 0; k < 40; k++)
                do_req(int'($urandom_range(N - 1, 0)), "R8", gl, gh);
        end
        finish_run();
    end
endmodule